// File: doc/BRIEF.md
# Masked Multicast Route Lookup

This block decides where a multicast event packet goes. Each packet carries a 32-bit source key. The block compares that key against a table of entries. Every entry holds a key, a mask and a route word, and a mask bit set to 1 makes that key position a don't-care. All entries are compared at the same time. When several entries match, the entry with the highest index wins, and its route word is sent out.

A route word is a 24-bit vector with one bit per destination. The six low bits select outgoing links and the eighteen high bits select local cores. When no entry matches, the block builds a default route from where the packet came from:
- A packet that arrived on a link leaves by the opposite link.
- A packet raised locally goes to the monitor core.
- A per-link diversion setting can send unmatched traffic from one link to the monitor, or drop it.

Entries are written at run time through a configuration port. An entry that has failed can be disabled, and its contents loaded into a spare entry. The lookup is pipelined: it accepts one key per cycle and gives the answer two cycles later.

Top module: `mcr_route_lookup`

## Requirements
- R1: After reset, `rt_valid`, `rt_route` and `rt_default` are 0 and every entry is disabled, so every key misses.
- R2: An enabled entry matches a key when every key bit whose mask bit is 0 equals the stored key bit. Mask bits that are 1 are ignored.
- R3: When several enabled entries match, the route of the highest-numbered entry is output. Specificity plays no part.
- R4: On a match, `rt_route` equals the stored 24-bit route word and `rt_default` is 0. Bits 5:0 of the route word are link 0..5 and bits 23:6 are core 0..17. Whenever `rt_valid` is 0, both `rt_route` and `rt_default` are 0.
- R5: A key presented with `pkt_valid` at a clock edge produces `rt_valid` and its result after the second following edge. Keys may be presented on consecutive cycles.
- R6: An entry written with `cfg_ent_valid`=0 never matches. Writing the same key, mask and route into another index restores the function.
- R7: On a miss for a packet from link L (0..5) whose diversion mode is 0, `rt_default` is 1 and only link bit (L+3) mod 6 is set.
- R8: On a miss for a packet with `pkt_local`=1, or with link code 6 or 7, `rt_default` is 1 and only bit 6 (core 0, the monitor) is set.
- R9: The diversion mode of each link is written with `cfg_div_we`. Mode 1 sends misses from that link to bit 6. Modes 2 and 3 discard them, giving a route of 0 with `rt_default`=1. Diversion affects only misses from its own link.
- R10: A configuration write at the same edge as a key does not affect that key. A key at the next edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Key present this cycle |
| pkt_key | input | 32 | Source key |
| pkt_local | input | 1 | Packet originated locally |
| pkt_link | input | 3 | Arrival link 0..5 |
| cfg_ent_we | input | 1 | Entry write strobe |
| cfg_ent_idx | input | IDX_W | Entry index |
| cfg_ent_valid | input | 1 | Entry enable |
| cfg_ent_key | input | 32 | Entry key |
| cfg_ent_mask | input | 32 | Entry mask, 1 = don't-care |
| cfg_ent_route | input | 24 | Entry route word |
| cfg_div_we | input | 1 | Diversion write strobe |
| cfg_div_link | input | 3 | Link whose diversion is written |
| cfg_div_mode | input | 2 | 0 opposite link, 1 monitor, 2/3 discard |
| rt_valid | output | 1 | Result valid |
| rt_route | output | 24 | Destination vector |
| rt_default | output | 1 | Result came from the default path |

## Verification
The hardest case to reach is a configuration write that lands on the same edge as a key it would change. The bench drives the entry write and the key on one cycle, then repeats the key on the next cycle. The first result must still be a miss and the second must be a hit. Back-to-back keys are also issued in a burst to show that results stay aligned with their keys. Priority is checked by overlapping a low-index specific entry with a higher-index catch-all entry.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int KEY_W   = 32;
  localparam int LINKS   = 6;
  localparam int CORES   = 18;
  localparam int ROUTE_W = LINKS + CORES;
  localparam int LINK_W  = 3;
  localparam int MON_BIT = LINKS;  // core 0 acts as monitor

  typedef enum logic [1:0] {
    DIV_OPP   = 2'd0,
    DIV_MON   = 2'd1,
    DIV_DROP  = 2'd2,
    DIV_DROPX = 2'd3
  } div_mode_e;
endpackage

// File: rtl/mcr_tcam_array.sv
module mcr_tcam_array #(
  parameter int N  = 16,
  parameter int KW = 32,
  parameter int RW = 24,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [KW-1:0] wr_key,
  input  logic [KW-1:0] wr_mask,
  input  logic [RW-1:0] wr_route,
  input  logic [KW-1:0] lk_key,
  output logic [N-1:0]  hit_vec,
  input  logic [IW-1:0] rd_idx,
  output logic [RW-1:0] rd_route
);
  logic [RW-1:0] route_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic          en_i;
    logic          vld_q;
    logic [KW-1:0] key_q;
    logic [KW-1:0] mask_q;
    logic [RW-1:0] route_q;

    assign en_i = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    vld_q <= 1'b0;
      else if (en_i) vld_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (en_i) begin
        key_q   <= wr_key;
        mask_q  <= wr_mask;
        route_q <= wr_route;
      end
    end

    assign hit_vec[i]   = vld_q && (((lk_key ^ key_q) & ~mask_q) == '0);
    assign route_arr[i] = route_q;
  end

  assign rd_route = route_arr[rd_idx];
endmodule

// File: rtl/mcr_prio_enc.sv
module mcr_prio_enc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IW'(i);  // later (higher) index overrides
    end
    any = |req;
  end
endmodule

// File: rtl/mcr_default_sel.sv
module mcr_default_sel
  import mcr_pkg::*;
(
  input  logic               hit,
  input  logic [ROUTE_W-1:0] hit_route,
  input  logic               local_src,
  input  logic [LINK_W-1:0]  link,
  input  logic [1:0]         mode,
  output logic [ROUTE_W-1:0] route,
  output logic               dflt
);
  logic [LINK_W-1:0] opp;

  always_comb begin
    opp = (link < LINK_W'(3)) ? link + LINK_W'(3) : link - LINK_W'(3);
    route = '0;
    dflt  = 1'b0;
    if (hit) begin
      route = hit_route;
    end else begin
      dflt = 1'b1;
      if (local_src || link >= LINK_W'(LINKS)) begin
        route[MON_BIT] = 1'b1;
      end else begin
        case (div_mode_e'(mode))
          DIV_OPP: route = ROUTE_W'(1) << opp;
          DIV_MON: route[MON_BIT] = 1'b1;
          default: route = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mcr_route_lookup.sv
module mcr_route_lookup
  import mcr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  input  logic [KEY_W-1:0]   pkt_key,
  input  logic               pkt_local,
  input  logic [LINK_W-1:0]  pkt_link,
  input  logic               cfg_ent_we,
  input  logic [IDX_W-1:0]   cfg_ent_idx,
  input  logic               cfg_ent_valid,
  input  logic [KEY_W-1:0]   cfg_ent_key,
  input  logic [KEY_W-1:0]   cfg_ent_mask,
  input  logic [ROUTE_W-1:0] cfg_ent_route,
  input  logic               cfg_div_we,
  input  logic [LINK_W-1:0]  cfg_div_link,
  input  logic [1:0]         cfg_div_mode,
  output logic               rt_valid,
  output logic [ROUTE_W-1:0] rt_route,
  output logic               rt_default
);
  logic [N_ENT-1:0]   hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [ROUTE_W-1:0] hit_route;

  logic [LINKS-1:0][1:0] div_q;
  logic [1:0]            mode_sel;

  logic               s1_vld_q, s1_hit_q, s1_local_q;
  logic [ROUTE_W-1:0] s1_route_q;
  logic [LINK_W-1:0]  s1_link_q;
  logic [1:0]         s1_mode_q;

  logic [ROUTE_W-1:0] s2_route_d;
  logic               s2_dflt_d;

  mcr_tcam_array #(.N(N_ENT), .KW(KEY_W), .RW(ROUTE_W)) u_tcam (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_ent_we),
    .wr_idx   (cfg_ent_idx),
    .wr_valid (cfg_ent_valid),
    .wr_key   (cfg_ent_key),
    .wr_mask  (cfg_ent_mask),
    .wr_route (cfg_ent_route),
    .lk_key   (pkt_key),
    .hit_vec  (hit_vec),
    .rd_idx   (hit_idx),
    .rd_route (hit_route)
  );

  mcr_prio_enc #(.N(N_ENT)) u_prio (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  // diversion mode of the arrival link
  always_comb begin
    mode_sel = DIV_OPP;
    for (int l = 0; l < LINKS; l++) begin
      if (pkt_link == LINK_W'(l)) mode_sel = div_q[l];
    end
  end

  for (genvar l = 0; l < LINKS; l++) begin : g_div
    logic div_en;
    assign div_en = cfg_div_we && (cfg_div_link == LINK_W'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q[l] <= DIV_OPP;
      else if (div_en) div_q[l] <= cfg_div_mode;
    end
  end

  // stage 1: match, winner and route captured together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q   <= 1'b0;
      s1_hit_q   <= 1'b0;
      s1_local_q <= 1'b0;
      s1_route_q <= '0;
      s1_link_q  <= '0;
      s1_mode_q  <= '0;
    end else begin
      s1_vld_q <= pkt_valid;
      if (pkt_valid) begin
        s1_hit_q   <= hit_any;
        s1_local_q <= pkt_local;
        s1_route_q <= hit_route;
        s1_link_q  <= pkt_link;
        s1_mode_q  <= mode_sel;
      end
    end
  end

  mcr_default_sel u_dflt (
    .hit       (s1_hit_q),
    .hit_route (s1_route_q),
    .local_src (s1_local_q),
    .link      (s1_link_q),
    .mode      (s1_mode_q),
    .route     (s2_route_d),
    .dflt      (s2_dflt_d)
  );

  // stage 2: registered result, quiet when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid   <= 1'b0;
      rt_route   <= '0;
      rt_default <= 1'b0;
    end else begin
      rt_valid   <= s1_vld_q;
      rt_route   <= s1_vld_q ? s2_route_d : '0;
      rt_default <= s1_vld_q && s2_dflt_d;
    end
  end
endmodule

// File: rtl/mcr_route_lookup_chk.sv
module mcr_route_lookup_chk
  import mcr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_valid,
  input logic               pkt_local,
  input logic               rt_valid,
  input logic [ROUTE_W-1:0] rt_route,
  input logic               rt_default
);
  logic v1_q, v2_q, l1_q, l2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; v2_q <= 1'b0; l1_q <= 1'b0; l2_q <= 1'b0;
    end else begin
      v1_q <= pkt_valid; v2_q <= v1_q;
      l1_q <= pkt_local; l2_q <= l1_q;
    end
  end

  a_r5_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid == v2_q);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_valid |-> (rt_route == '0 && !rt_default));

  a_r7_default_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_default) |-> $onehot0(rt_route));

  a_r8_local_miss_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_default && l2_q) |-> rt_route == (ROUTE_W'(1) << MON_BIT));
endmodule

bind mcr_route_lookup mcr_route_lookup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_valid  (pkt_valid),
  .pkt_local  (pkt_local),
  .rt_valid   (rt_valid),
  .rt_route   (rt_route),
  .rt_default (rt_default)
);

// File: tb/test_mcr_route_lookup.sv
module test_mcr_route_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int IW  = $clog2(N);
  localparam logic [23:0] MON = 24'h000040;
  localparam logic [23:0] RA = 24'h000080, RB = 24'h040001, RC = 24'h100002;
  localparam logic [23:0] RE = 24'h000105, RR = 24'h800020;
  localparam logic [23:0] RD = {18'h2AAAA, 6'b010110};

  logic clk = 1'b0, rst_n;
  logic pkt_valid, pkt_local, cfg_ent_we, cfg_ent_valid, cfg_div_we;
  logic [31:0] pkt_key, cfg_ent_key, cfg_ent_mask;
  logic [2:0] pkt_link, cfg_div_link;
  logic [IW-1:0] cfg_ent_idx;
  logic [23:0] cfg_ent_route, rt_route;
  logic [1:0] cfg_div_mode;
  logic rt_valid, rt_default;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcr_route_lookup #(.N_ENT(N)) i_mcr_route_lookup (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_entry(int idx, bit v, logic [31:0] k, logic [31:0] m, logic [23:0] r);
    @(negedge clk);
    cfg_ent_we = 1; cfg_ent_idx = IW'(idx); cfg_ent_valid = v;
    cfg_ent_key = k; cfg_ent_mask = m; cfg_ent_route = r;
    @(negedge clk);
    cfg_ent_we = 0;
  endtask

  task automatic write_div(int link, logic [1:0] mode);
    @(negedge clk);
    cfg_div_we = 1; cfg_div_link = 3'(link); cfg_div_mode = mode;
    @(negedge clk);
    cfg_div_we = 0;
  endtask

  task automatic lookup(string req, logic [31:0] k, bit loc, int link,
                        logic [23:0] exp_r, bit exp_d);
    @(negedge clk);
    pkt_valid = 1; pkt_key = k; pkt_local = loc; pkt_link = 3'(link);
    @(negedge clk);
    pkt_valid = 0;
    check({req, " valid early"}, {31'd0, rt_valid}, 32'd0);
    @(negedge clk);
    check({req, " valid"}, {31'd0, rt_valid}, 32'd1);
    check({req, " route"}, {8'd0, rt_route}, {8'd0, exp_r});
    check({req, " default"}, {31'd0, rt_default}, {31'd0, exp_d});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, rt_valid}, 0);
    check("R1 route", {8'd0, rt_route}, 0);
    check("R1 default", {31'd0, rt_default}, 0);
    lookup("R1 empty table miss", 32'h12345678, 0, 0, 24'h000008, 1);
  endtask

  task automatic t_ternary;
    write_entry(2, 1, 32'hABCD0000, 32'h0000FFFF, RE);
    lookup("R2 masked bits ignored", 32'hABCD1234, 0, 1, RE, 0);
    lookup("R2 care bit differs", 32'hABCE1234, 0, 1, 24'h000010, 1);
  endtask

  task automatic t_default;
    lookup("R7 link5 to link2", 32'h55555555, 0, 5, 24'h000004, 1);
    lookup("R8 local miss", 32'h55555555, 1, 2, MON, 1);
    lookup("R8 link code 6", 32'h55555555, 0, 6, MON, 1);
  endtask

  task automatic t_divert;
    write_div(2, 2'd1);
    lookup("R9 divert to monitor", 32'h66666666, 0, 2, MON, 1);
    lookup("R9 other link unaffected", 32'h66666666, 0, 4, 24'h000002, 1);
    write_div(2, 2'd2);
    lookup("R9 discard", 32'h66666666, 0, 2, 24'h0, 1);
    lookup("R9 hit ignores divert", 32'hABCD0000, 0, 2, RE, 0);
    write_div(2, 2'd0);
    lookup("R9 back to opposite", 32'h66666666, 0, 2, 24'h000020, 1);
  endtask

  task automatic t_cfg_race;
    @(negedge clk);
    pkt_valid = 1; pkt_key = 32'h77770000; pkt_local = 0; pkt_link = 3'd0;
    cfg_ent_we = 1; cfg_ent_idx = IW'(7); cfg_ent_valid = 1;
    cfg_ent_key = 32'h77770000; cfg_ent_mask = 32'h0; cfg_ent_route = RR;
    @(negedge clk);
    cfg_ent_we = 0;
    @(negedge clk);
    pkt_valid = 0;
    check("R10 same-edge key misses", {8'd0, rt_route}, 32'h000008);
    check("R10 same-edge default", {31'd0, rt_default}, 1);
    @(negedge clk);
    check("R10 next key hits", {8'd0, rt_route}, {8'd0, RR});
    check("R10 next key not default", {31'd0, rt_default}, 0);
  endtask

  task automatic t_priority;
    write_entry(5, 1, 32'h0, 32'hFFFFFFFF, RA);
    write_entry(9, 1, 32'h12340000, 32'h0000FFFF, RB);
    write_entry(3, 1, 32'h12345678, 32'h0, RC);
    lookup("R3 three hits, index 9 wins", 32'h12345678, 0, 0, RB, 0);
    lookup("R3 catch-all only", 32'h99999999, 0, 0, RA, 0);
    lookup("R3 index 5 beats 2", 32'hABCD0001, 0, 0, RA, 0);
  endtask

  task automatic t_fields;
    write_entry(12, 1, 32'h0F0F0F0F, 32'h0, RD);
    lookup("R4 full route word", 32'h0F0F0F0F, 0, 3, RD, 0);
    check("R4 link bits", {26'd0, rt_route[5:0]}, 32'b010110);
    check("R4 core bits", {14'd0, rt_route[23:6]}, 32'h2AAAA);
  endtask

  task automatic t_disable;
    write_entry(12, 0, 32'h0F0F0F0F, 32'h0, RD);
    lookup("R6 disabled entry", 32'h0F0F0F0F, 0, 3, RA, 0);
    write_entry(14, 1, 32'h0F0F0F0F, 32'h0, RD);
    lookup("R6 spare restores", 32'h0F0F0F0F, 0, 3, RD, 0);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    pkt_valid = 1; pkt_key = 32'h12345678; pkt_local = 0; pkt_link = 3'd0;
    @(negedge clk);
    check("R5 burst no early result", {31'd0, rt_valid}, 0);
    pkt_key = 32'h0F0F0F0F;
    @(negedge clk);
    check("R5 burst key0", {8'd0, rt_route}, {8'd0, RB});
    pkt_key = 32'hABCD1234;
    @(negedge clk);
    pkt_valid = 0;
    check("R5 burst key1", {8'd0, rt_route}, {8'd0, RD});
    @(negedge clk);
    check("R5 burst key2", {8'd0, rt_route}, {8'd0, RA});
    check("R5 burst key2 valid", {31'd0, rt_valid}, 1);
    @(negedge clk);
    check("R5 burst drains", {31'd0, rt_valid}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pkt_valid = 0; pkt_local = 0; pkt_key = '0; pkt_link = '0;
    cfg_ent_we = 0; cfg_ent_valid = 0; cfg_ent_idx = '0; cfg_ent_key = '0;
    cfg_ent_mask = '0; cfg_ent_route = '0;
    cfg_div_we = 0; cfg_div_link = '0; cfg_div_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ternary;
    t_default;
    t_divert;
    t_cfg_race;
    t_priority;
    t_fields;
    t_disable;
    t_pipeline;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule